// File: doc/BRIEF.md
# Clock Source Switch Controller

This block picks the system clock source: a primary oscillator, which may be a crystal or resonator, or an internal secondary oscillator. It covers four situations. After reset it can run from the secondary oscillator first and move to the primary only once the primary has settled (two-speed start-up). If the primary dies it can fall back to the secondary (fail-safe). Software can move between the sources with a source-select bit or by changing the internal frequency select. A wake-up from sleep can restart the settling sequence. The block decides which source is selected. It does not contain the glitch-free clock multiplexer or the oscillator failure detector.

The block uses one counter for two jobs. While the primary is settling, the counter counts primary oscillator pulses as a start-up timer. At all other times it counts secondary oscillator pulses as the watchdog. The watchdog therefore cannot count or time out during settling, and every completed switch clears the counter, so the watchdog restarts in step with the new clock. All logic runs on one system clock. The two oscillators arrive as single-cycle tick strobes. The primary mode code is a configuration input and changes only while reset is held.

Top module: `clk_switch_ctrl`

## Requirements
- R1: On reset the select (`clk_sel_o`, 1 = secondary) is loaded as follows. For a crystal mode with `src_sel_i` = 1 it is 1. For a crystal mode with `src_sel_i` = 0 it is 1 if two-speed or fail-safe is enabled and 0 otherwise. For any other mode it is 0. `switch_done_o` and `wdt_timeout_o` read 0 after reset.
- R2: The crystal modes are `prim_mode_i` = 3'b000, 3'b001 and 3'b010. Codes 3'b011 and 3'b100 to 3'b111 need no start-up timer. In those codes the select stays at 0, and source select, wake and failure cause no switch and no `switch_done_o`.
- R3: While the primary is settling the select is 1. It returns to 0 on the rising edge that samples the OST_CYCLES-th `prim_tick_i` of the settling period, and not earlier. `switch_done_o` pulses on that same edge.
- R4: With `fail_safe_en_i` = 1, in a crystal mode, while running from the primary, a high `osc_fail_i` passes through a two-flop synchroniser. The select becomes 1 and `switch_done_o` pulses on the third rising edge that samples it high. With `fail_safe_en_i` = 0 the failure is ignored.
- R5: After a failure fallback the select stays at 1 until reset. Source select, wake, frequency-select changes, further failures and primary ticks cause no switch and no `switch_done_o`.
- R6: A rise of `src_sel_i` while on the primary sets the select to 1 with a `switch_done_o` pulse on the next edge. A fall of `src_sel_i` while on the secondary starts a settling period, which ends as in R3.
- R7: A `wake_i` pulse while on the primary starts a settling period (select 1, no done pulse) only if the mode is a crystal mode, `src_sel_i` = 0, and two-speed or fail-safe is enabled. Otherwise it is ignored.
- R8: A change of `frq_sel_i` while on the secondary by software choice pulses `switch_done_o`, leaves the select at 1 and clears the watchdog count.
- R9: Outside settling, `wdt_timeout_o` pulses for one cycle on the edge that samples the WDT_LIMIT-th `sec_tick_i` since the count was last cleared, and the count then restarts from zero.
- R10: During a settling period `sec_tick_i` is not counted and `wdt_timeout_o` stays 0.
- R11: Every completed transition clears the shared count, so the next timeout needs a full WDT_LIMIT secondary ticks.
- R12: Each `switch_done_o` event lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset (power-on or device reset) |
| prim_mode_i | input | 3 | Primary oscillator mode code |
| src_sel_i | input | 1 | Software source select, 1 = internal secondary |
| frq_sel_i | input | FRQ_W | Internal oscillator frequency select |
| two_speed_en_i | input | 1 | Two-speed start-up enable |
| fail_safe_en_i | input | 1 | Fail-safe fallback enable |
| wake_i | input | 1 | Wake from sleep by interrupt or watchdog, one-cycle pulse |
| osc_fail_i | input | 1 | Primary failure flag, asynchronous |
| prim_tick_i | input | 1 | One pulse per primary oscillator cycle |
| sec_tick_i | input | 1 | One pulse per secondary oscillator cycle |
| clk_sel_o | output | 1 | Selected source, 1 = secondary |
| switch_done_o | output | 1 | Transition complete pulse |
| wdt_timeout_o | output | 1 | Watchdog timeout pulse |

## Verification
A wrong state register shows up directly on `clk_sel_o`, because the select is registered from the next state on the same edge. A wrong settling count appears as the select returning to the primary one or more primary ticks early or late, so the bench counts the ticks it sends and compares at the exact tick. A counter that is not blocked during settling, or not cleared on a transition, appears as a `wdt_timeout_o` pulse inside settling or after fewer than WDT_LIMIT secondary ticks. That error becomes visible at most one watchdog period after the fault. A wrong synchroniser depth moves the fallback edge by whole cycles.

// File: rtl/clksw_pkg.sv
package clksw_pkg;

  typedef enum logic [1:0] {
    ST_RUN_PRI = 2'd0,  // running from primary
    ST_RUN_SEC = 2'd1,  // running from secondary by software choice
    ST_OST     = 2'd2,  // on secondary, primary settling
    ST_FAILED  = 2'd3   // fallback after primary loss, held until reset
  } clksw_state_e;

  // crystal/resonator modes need the start-up timer
  function automatic logic is_crystal(input logic [2:0] mode);
    return (mode == 3'b000) || (mode == 3'b001) || (mode == 3'b010);
  endfunction

endpackage

// File: rtl/clksw_sync.sv
module clksw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) sh_q <= '0;
    else       sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/clksw_evt.sv
module clksw_evt #(
  parameter int FRQ_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             src_i,
  input  logic [FRQ_W-1:0] frq_i,
  output logic             src_rise_o,
  output logic             src_fall_o,
  output logic             frq_chg_o
);
  logic             src_q;
  logic [FRQ_W-1:0] frq_q;

  // reset loads current values so reset itself is not seen as an edge
  always_ff @(posedge clk_i) begin
    src_q <= src_i;
    frq_q <= frq_i;
  end

  assign src_rise_o = !rst_i &&  src_i && !src_q;
  assign src_fall_o = !rst_i && !src_i &&  src_q;
  assign frq_chg_o  = !rst_i && (frq_i != frq_q);
endmodule

// File: rtl/clksw_shared_ctr.sv
module clksw_shared_ctr #(
  parameter int OST_CYCLES = 1024,
  parameter int WDT_LIMIT  = 65536
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic ost_mode_i,   // 1: start-up timer on primary ticks
  input  logic clr_i,        // transition complete or started
  input  logic prim_tick_i,
  input  logic sec_tick_i,
  output logic ost_last_o,   // final settling tick this cycle
  output logic wdt_hit_o     // final watchdog tick this cycle
);
  localparam int MAXC = (OST_CYCLES > WDT_LIMIT) ? OST_CYCLES : WDT_LIMIT;
  localparam int CW   = $clog2(MAXC);

  logic [CW-1:0] cnt_q;
  logic          step;

  assign step       = ost_mode_i ? prim_tick_i : sec_tick_i;
  assign ost_last_o = ost_mode_i && prim_tick_i && (cnt_q == CW'(OST_CYCLES - 1));
  assign wdt_hit_o  = !ost_mode_i && sec_tick_i && (cnt_q == CW'(WDT_LIMIT - 1));

  always_ff @(posedge clk_i) begin
    if (rst_i || clr_i || wdt_hit_o) cnt_q <= '0;
    else if (step)                   cnt_q <= cnt_q + CW'(1);
  end

  // R11: a clear request always leaves the count at zero
  p_clear_zero_r11: assert property (@(posedge clk_i) disable iff (rst_i)
    clr_i |=> (cnt_q == '0));

  // R9: after a timeout the watchdog restarts from zero
  p_wdt_restart_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    wdt_hit_o |=> (cnt_q == '0));

  // R3: settling never counts past its terminal value
  p_ost_bound_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    ost_mode_i |-> (int'(cnt_q) < OST_CYCLES));
endmodule

// File: rtl/clk_switch_ctrl.sv
module clk_switch_ctrl
  import clksw_pkg::*;
#(
  parameter int OST_CYCLES  = 1024,
  parameter int WDT_LIMIT   = 65536,
  parameter int SYNC_STAGES = 2,
  parameter int FRQ_W       = 3
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [2:0]       prim_mode_i,
  input  logic             src_sel_i,
  input  logic [FRQ_W-1:0] frq_sel_i,
  input  logic             two_speed_en_i,
  input  logic             fail_safe_en_i,
  input  logic             wake_i,
  input  logic             osc_fail_i,
  input  logic             prim_tick_i,
  input  logic             sec_tick_i,
  output logic             clk_sel_o,
  output logic             switch_done_o,
  output logic             wdt_timeout_o
);
  clksw_state_e state_q, nxt, rst_st;
  logic crystal, ts_any, fail_s;
  logic src_rise, src_fall, frq_chg;
  logic ost_last, wdt_hit, done_c, clr_c;

  assign crystal = is_crystal(prim_mode_i);
  assign ts_any  = two_speed_en_i || fail_safe_en_i;

  clksw_sync #(.STAGES(SYNC_STAGES)) u_fail_sync (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (osc_fail_i),
    .q_o   (fail_s)
  );

  clksw_evt #(.FRQ_W(FRQ_W)) u_evt (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .src_i      (src_sel_i),
    .frq_i      (frq_sel_i),
    .src_rise_o (src_rise),
    .src_fall_o (src_fall),
    .frq_chg_o  (frq_chg)
  );

  clksw_shared_ctr #(.OST_CYCLES(OST_CYCLES), .WDT_LIMIT(WDT_LIMIT)) u_ctr (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .ost_mode_i  (state_q == ST_OST),
    .clr_i       (clr_c),
    .prim_tick_i (prim_tick_i),
    .sec_tick_i  (sec_tick_i),
    .ost_last_o  (ost_last),
    .wdt_hit_o   (wdt_hit)
  );

  // state loaded while reset is held
  always_comb begin
    if (!crystal)      rst_st = ST_RUN_PRI;
    else if (src_sel_i) rst_st = ST_RUN_SEC;
    else if (ts_any)    rst_st = ST_OST;
    else                rst_st = ST_RUN_PRI;
  end

  always_comb begin
    nxt    = state_q;
    done_c = 1'b0;
    clr_c  = 1'b0;
    unique case (state_q)
      ST_RUN_PRI: begin
        if (crystal) begin
          if (fail_safe_en_i && fail_s) begin
            nxt = ST_FAILED;  done_c = 1'b1; clr_c = 1'b1;
          end else if (src_rise) begin
            nxt = ST_RUN_SEC; done_c = 1'b1; clr_c = 1'b1;
          end else if (wake_i && ts_any && !src_sel_i) begin
            nxt = ST_OST;     clr_c = 1'b1;
          end
        end
      end
      ST_RUN_SEC: begin
        if (src_fall) begin
          nxt = ST_OST; clr_c = 1'b1;
        end else if (frq_chg) begin
          done_c = 1'b1; clr_c = 1'b1;
        end
      end
      ST_OST: begin
        if (src_rise) begin
          nxt = ST_RUN_SEC; done_c = 1'b1; clr_c = 1'b1;
        end else if (ost_last) begin
          nxt = ST_RUN_PRI; done_c = 1'b1; clr_c = 1'b1;
        end
      end
      ST_FAILED: ;
      default: nxt = ST_RUN_PRI;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q       <= rst_st;
      clk_sel_o     <= (rst_st != ST_RUN_PRI);
      switch_done_o <= 1'b0;
      wdt_timeout_o <= 1'b0;
    end else begin
      state_q       <= nxt;
      clk_sel_o     <= (nxt != ST_RUN_PRI);
      switch_done_o <= done_c;
      wdt_timeout_o <= wdt_hit;
    end
  end

  // R10: no timeout can come out of a settling cycle
  p_no_wdt_in_ost_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q == ST_OST) |=> !wdt_timeout_o);

  // R5: fallback is held until reset
  p_fail_sticky_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q == ST_FAILED) |=> ((state_q == ST_FAILED) && clk_sel_o));

  // R2: non-crystal modes never leave the primary
  p_nonxtal_primary_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    !crystal |-> (state_q == ST_RUN_PRI));

  // R3: terminal settling tick hands back to the primary with a done pulse
  p_ost_return_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    ((state_q == ST_OST) && !src_rise && ost_last) |=> (!clk_sel_o && switch_done_o));

  // R4: synchronised failure on the primary forces the fallback
  p_fail_to_sec_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    ((state_q == ST_RUN_PRI) && crystal && fail_safe_en_i && fail_s)
      |=> (clk_sel_o && switch_done_o));
endmodule

// File: tb/clk_switch_ctrl_tb_top.sv
`timescale 1ns/1ps
module clk_switch_ctrl_tb_top;
  localparam int OSTN = 1024;
  localparam int WDTN = 256;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] mode = 3'b001;
  logic       src = 1'b0;
  logic [2:0] frq = 3'd0;
  logic       ts = 1'b0, fs = 1'b0, wake = 1'b0, fail = 1'b0;
  logic       ptick = 1'b0, stick = 1'b0;
  logic       sel, done, wdt;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  clk_switch_ctrl #(.OST_CYCLES(OSTN), .WDT_LIMIT(WDTN)) dut_i (
    .clk_i(clk), .rst_i(rst), .prim_mode_i(mode), .src_sel_i(src), .frq_sel_i(frq),
    .two_speed_en_i(ts), .fail_safe_en_i(fs), .wake_i(wake), .osc_fail_i(fail),
    .prim_tick_i(ptick), .sec_tick_i(stick),
    .clk_sel_o(sel), .switch_done_o(done), .wdt_timeout_o(wdt));

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic exp_reset_sel(input logic [2:0] m, input logic s,
                                         input logic t, input logic f);
    if (!(m == 3'b000 || m == 3'b001 || m == 3'b010)) return 1'b0;
    if (s) return 1'b1;
    return t | f;
  endfunction

  task automatic do_reset(input logic [2:0] m, input logic s, input logic t, input logic f);
    mode = m; src = s; ts = t; fs = f; wake = 0; fail = 0; ptick = 0; stick = 0;
    rst = 1; step(); step(); rst = 0;
  endtask

  // drive primary ticks at random until the settling period ends
  task automatic finish_ost(input string req);
    int n = 0;
    bit early = 0;
    while (n < OSTN) begin
      logic p;
      p = 1'($urandom % 2);
      ptick = p; step();
      if (p) n++;
      if (n < OSTN && (sel !== 1'b1 || done !== 1'b0)) early = 1;
    end
    ptick = 0;
    chk({req, " no early return"}, early, 0);
    chk({req, " select back to primary"}, sel, 0);
    chk({req, " done pulse"}, done, 1);
    step();
    chk("R12 done one cycle", done, 0);
  endtask

  // secondary ticks at random; returns tick count at the timeout
  task automatic run_wdt(output int got);
    int n = 0;
    got = -1;
    for (int i = 0; i < 4000; i++) begin
      logic s;
      s = 1'($urandom % 2);
      stick = s; step();
      if (s) n++;
      if (wdt) begin got = n; break; end
    end
    stick = 0;
  endtask

  initial begin
    int got, cnt_to;
    void'($urandom(32'd4242));

    // R1 / R10 / R3 / R11 / R9
    do_reset(3'b001, 0, 1, 0);
    chk("R1 reset select two-speed", sel, 1);
    chk("R1 reset done", done, 0);
    chk("R1 reset timeout", wdt, 0);
    cnt_to = 0;
    stick = 1;
    for (int i = 0; i < 600; i++) begin step(); if (wdt) cnt_to++; end
    stick = 0;
    chk("R10 no timeout while settling", cnt_to, 0);
    chk("R10 still on secondary", sel, 1);
    finish_ost("R3");
    run_wdt(got);
    chk("R11 full period after transition", got, WDTN);
    step();
    chk("R9 timeout one cycle", wdt, 0);
    run_wdt(got);
    chk("R9 second period", got, WDTN);

    // R6 / R8
    src = 1; step();
    chk("R6 rise to secondary", sel, 1);
    chk("R6 rise done", done, 1);
    step();
    chk("R12 done one cycle", done, 0);
    stick = 1;
    for (int i = 0; i < 100; i++) step();
    stick = 0;
    frq = 3'd5; step();
    chk("R8 freq change done", done, 1);
    chk("R8 select kept", sel, 1);
    run_wdt(got);
    chk("R8 count cleared", got, WDTN);
    src = 0; step();
    chk("R6 fall starts settling", sel, 1);
    chk("R6 fall no done", done, 0);
    finish_ost("R6");

    // R7
    wake = 1; step(); wake = 0;
    chk("R7 wake starts settling", sel, 1);
    chk("R7 wake no done", done, 0);
    finish_ost("R7");
    ts = 0;
    wake = 1; step(); wake = 0; step();
    chk("R7 wake ignored without enables", sel, 0);
    chk("R7 wake ignored done", done, 0);

    // R4 / R5
    fail = 1;
    for (int i = 0; i < 6; i++) step();
    chk("R4 failure ignored when disabled", sel, 0);
    fail = 0; step(); step(); step();
    fs = 1; fail = 1; step(); step();
    chk("R4 sync latency", sel, 0);
    step();
    chk("R4 fallback select", sel, 1);
    chk("R4 fallback done", done, 1);
    fail = 0;
    cnt_to = 0;
    for (int i = 0; i < 40; i++) begin
      src = (i % 10) < 5;
      wake = (i % 7) == 0;
      fail = (i % 3) == 0;
      frq = 3'(i / 4);
      ptick = 1;
      step();
      if (done) cnt_to++;
    end
    ptick = 1;
    for (int i = 0; i < OSTN + 10; i++) begin step(); if (done || !sel) cnt_to++; end
    ptick = 0; src = 0; wake = 0; fail = 0;
    chk("R5 no done after fallback", cnt_to, 0);
    chk("R5 held on secondary", sel, 1);

    // R2
    do_reset(3'b100, 0, 1, 1);
    chk("R2 non-crystal reset select", sel, 0);
    cnt_to = 0;
    src = 1; step(); if (done) cnt_to++;
    wake = 1; step(); wake = 0; if (done) cnt_to++;
    fail = 1; for (int i = 0; i < 5; i++) begin step(); if (done) cnt_to++; end
    fail = 0;
    chk("R2 non-crystal select stays", sel, 0);
    chk("R2 non-crystal no done", cnt_to, 0);
    do_reset(3'b011, 0, 1, 0);
    chk("R2 code 3 no start-up", sel, 0);

    // R1 directed and random
    do_reset(3'b010, 0, 0, 0);
    chk("R1 crystal no enables", sel, 0);
    do_reset(3'b000, 1, 0, 0);
    chk("R1 crystal src_sel set", sel, 1);
    for (int i = 0; i < 10; i++) begin
      logic [2:0] m;
      logic s, t, f;
      m = 3'($urandom); s = 1'($urandom); t = 1'($urandom); f = 1'($urandom);
      do_reset(m, s, t, f);
      chk("R1 random reset select", sel, exp_reset_sel(m, s, t, f));
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got hung expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule